// File: doc/BRIEF.md
# Multiload Page Loader Engine

This engine fills the three writable RAM banks of a multi-load game cartridge from a stored program image. A stored image is a series of load records. Each record holds a fixed number of data pages, followed by one header page. On a request the engine walks the records in order and stops at the first one whose identifier byte matches the requested load number. It checks the header, then copies each listed page to the bank and page that the page's descriptor byte names. Last, it writes three header bytes into console RAM so that the boot code can pick up the start vector and the bank setting.

The engine reads the image one byte per clock through a combinational byte-read port. It writes through a single-byte RAM write port and a separate console write port. A checksum mismatch raises a sticky error flag but does not stop the load. A request for a load that is absent raises a not-found flag and writes nothing. Completion is marked by a one-cycle done pulse. While the engine is busy, further requests are ignored.

Top module: `multiload_engine`

## Requirements
- R1: The engine compares header byte 5 of each record against `req_load`, for record indices 0 up to `num_loads`-1 in ascending order. It loads the first record that matches. Record i starts at image address i*8448: 32 pages of 256 bytes, then a 256-byte header at offset 8192.
- R2: When no record within `num_loads` matches, `not_found` is set and `done` pulses. No RAM write and no console write takes place.
- R3: When the 8-bit wrapping sum of header bytes 0..7 is not 0x55, `hdr_err` is set. The pages are still copied.
- R4: Header byte 3 gives the page count n. Page j (j < n) is read from record offset j*256.
- R5: For page j, header byte 16+j is the descriptor. Descriptor bits [1:0] give the bank and bits [4:2] give the page. Byte b of the page is written to RAM address bank*2048 + page*256 + b.
- R6: A page whose descriptor bank field equals 3 is not written.
- R7: For each page, the engine takes the 8-bit sum of its 256 bytes, its descriptor and its check byte (header byte 64+j). If that sum differs from 0x55, `page_err` is set. The page is still written, whether or not it is skipped under R6.
- R8: After the pages are copied, the engine writes header byte 0 to console address 0xFE, then byte 1 to 0xFF, then byte 2 to 0x80.
- R9: The engine moves one byte per clock. When the request is accepted and record k matches with n pages, `busy` stays high for exactly 13 + k + 258*n cycles. For a miss it stays high for `num_loads` + 1 cycles.
- R10: `done` is high for one cycle only, at a time when `busy` is low. A request raised while busy has no effect. Accepting a request clears all three error flags.
- R11: After reset, `busy`, `done` and all flags are low, and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start request, taken when idle |
| req_load | input | 8 | Requested load identifier |
| num_loads | input | NL_W (3) | Number of records held in the image |
| img_addr | output | IMG_AW (16) | Image byte address |
| img_data | input | 8 | Image byte at `img_addr`, same cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW (13) | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| host_we | output | 1 | Console RAM write strobe |
| host_addr | output | 8 | Console RAM address |
| host_wdata | output | 8 | Console RAM write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| hdr_err | output | 1 | Header checksum mismatch seen |
| page_err | output | 1 | Page checksum mismatch seen |
| not_found | output | 1 | Requested load absent |

## Verification
The image is four records produced by formulas, so every data byte, header byte and check byte is known to the bench. Two records share an identifier, so the test shows whether the engine picks the first match or a later one. One record sends a page to bank 3 and one page has a bad check byte, which separates skipped pages from copied ones and page errors from header errors. A record with a corrupted header sum shows that the engine flags the error and still copies the pages. Requests with a reduced or zero `num_loads` show that the search respects its bound, and a request injected mid-run shows that the engine ignores it. After every run the bench compares the full RAM and console images and the busy-cycle count with the values its own model predicts.

// File: rtl/ml_pkg.sv
package ml_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_SCAN, ST_HDR, ST_DESC, ST_CHK, ST_DATA, ST_HOST
   } ml_state_e;

   localparam logic [7:0] SUM_TARGET = 8'h55;
   localparam logic [7:0] HOST_VEC_LO = 8'hFE;
   localparam logic [7:0] HOST_VEC_HI = 8'hFF;
   localparam logic [7:0] HOST_CFG    = 8'h80;
endpackage

// File: rtl/ml_sum8.sv
module ml_sum8 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       add,
   input  logic [7:0] din,
   output logic [7:0] sum_nxt
);
   logic [7:0] acc;

   assign sum_nxt = acc + din;

   always_ff @(posedge clk) begin
      if (!rst_n)    acc <= '0;
      else if (load) acc <= din;
      else if (add)  acc <= sum_nxt;
   end
endmodule

// File: rtl/ml_dest_map.sv
module ml_dest_map #(
   parameter int PAGE_BYTES = 256,
   parameter int BANK_PAGES = 8,
   parameter int RAM_BANKS  = 3,
   parameter int RAM_AW     = 13
) (
   input  logic [4:0]                      desc,
   input  logic [$clog2(PAGE_BYTES)-1:0]   offset,
   output logic [RAM_AW-1:0]               addr,
   output logic                            skip
);
   localparam int PB_W   = $clog2(PAGE_BYTES);
   localparam int BANK_B = BANK_PAGES * PAGE_BYTES;
   localparam int WIDE   = RAM_AW + 2;

   logic [1:0]      bank;
   logic [2:0]      page;
   logic [WIDE-1:0] full;

   assign bank = desc[1:0];
   assign page = desc[4:2];
   assign skip = (int'(bank) >= RAM_BANKS);

   generate
      if ((1 << PB_W) == PAGE_BYTES && BANK_PAGES == 8) begin : g_pow2
         assign full = WIDE'({bank, page, offset});
      end else begin : g_mult
         assign full = WIDE'(bank) * WIDE'(BANK_B) + WIDE'(page) * WIDE'(PAGE_BYTES)
                     + WIDE'(offset);
      end
   endgenerate

   assign addr = full[RAM_AW-1:0];
endmodule

// File: rtl/multiload_engine.sv
module multiload_engine #(
   parameter int PAGE_BYTES    = 256,
   parameter int DATA_PAGES    = 32,
   parameter int BANK_PAGES    = 8,
   parameter int RAM_BANKS     = 3,
   parameter int MAX_LOADS     = 4,
   parameter int ID_OFS        = 5,
   parameter int COUNT_OFS     = 3,
   parameter int DESC_OFS      = 16,
   parameter int CHK_OFS       = 64,
   parameter int HDR_SUM_BYTES = 8,
   localparam int NL_W   = $clog2(MAX_LOADS + 1),
   localparam int IMG_AW = $clog2(MAX_LOADS * (DATA_PAGES + 1) * PAGE_BYTES + 1),
   localparam int RAM_AW = $clog2(RAM_BANKS * BANK_PAGES * PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [7:0]        req_load,
   input  logic [NL_W-1:0]   num_loads,
   output logic [IMG_AW-1:0] img_addr,
   input  logic [7:0]        img_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              host_we,
   output logic [7:0]        host_addr,
   output logic [7:0]        host_wdata,
   output logic              busy,
   output logic              done,
   output logic              hdr_err,
   output logic              page_err,
   output logic              not_found
);
   import ml_pkg::*;

   localparam int PB_W       = $clog2(PAGE_BYTES);
   localparam int PG_W       = $clog2(DATA_PAGES + 1);
   localparam int HDR_BASE   = DATA_PAGES * PAGE_BYTES;
   localparam int LOAD_BYTES = HDR_BASE + PAGE_BYTES;

   generate
      if (CHK_OFS + DATA_PAGES > PAGE_BYTES) begin : g_bad_chk
         $error("check bytes do not fit in the header page");
      end
      if (DESC_OFS + DATA_PAGES > CHK_OFS) begin : g_bad_desc
         $error("descriptor bytes overlap the check bytes");
      end
      if (RAM_BANKS > 3 || BANK_PAGES != 8) begin : g_bad_bank
         $error("descriptor fields hold banks 0..2 of 8 pages");
      end
      if (HDR_SUM_BYTES < 4 || HDR_SUM_BYTES > DESC_OFS) begin : g_bad_sum
         $error("header sum range must cover bytes 0..3");
      end
   endgenerate

   ml_state_e         st;
   logic [NL_W-1:0]   lidx, nl_q;
   logic [IMG_AW-1:0] base;
   logic [7:0]        id_q;
   logic [PB_W-1:0]   cnt;
   logic [PG_W-1:0]   pj, npg;
   logic [4:0]        desc_q;
   logic [7:0]        hb0, hb1, hb2;
   logic [7:0]        sum_nxt;
   logic              sum_load, sum_add, skip;

   ml_sum8 u_sum (
      .clk(clk), .rst_n(rst_n), .load(sum_load), .add(sum_add),
      .din(img_data), .sum_nxt(sum_nxt)
   );

   ml_dest_map #(
      .PAGE_BYTES(PAGE_BYTES), .BANK_PAGES(BANK_PAGES),
      .RAM_BANKS(RAM_BANKS), .RAM_AW(RAM_AW)
   ) u_map (
      .desc(desc_q), .offset(cnt), .addr(ram_addr), .skip(skip)
   );

   assign sum_load = (st == ST_HDR && cnt == '0) || st == ST_DESC;
   assign sum_add  = st == ST_HDR || st == ST_CHK || st == ST_DATA;

   always_comb begin
      unique case (st)
         ST_SCAN: img_addr = base + IMG_AW'(HDR_BASE + ID_OFS);
         ST_HDR:  img_addr = base + IMG_AW'(HDR_BASE) + IMG_AW'(cnt);
         ST_DESC: img_addr = base + IMG_AW'(HDR_BASE + DESC_OFS) + IMG_AW'(pj);
         ST_CHK:  img_addr = base + IMG_AW'(HDR_BASE + CHK_OFS) + IMG_AW'(pj);
         ST_DATA: img_addr = base + IMG_AW'(pj) * IMG_AW'(PAGE_BYTES) + IMG_AW'(cnt);
         default: img_addr = '0;
      endcase
   end

   assign ram_we    = (st == ST_DATA) && !skip;
   assign ram_wdata = img_data;
   assign host_we   = (st == ST_HOST);

   always_comb begin
      unique case (cnt[1:0])
         2'd0:    begin host_addr = HOST_VEC_LO; host_wdata = hb0; end
         2'd1:    begin host_addr = HOST_VEC_HI; host_wdata = hb1; end
         default: begin host_addr = HOST_CFG;    host_wdata = hb2; end
      endcase
   end

   assign busy = (st != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; lidx <= '0; nl_q <= '0; base <= '0; id_q <= '0;
         cnt <= '0; pj <= '0; npg <= '0; desc_q <= '0;
         hb0 <= '0; hb1 <= '0; hb2 <= '0;
         done <= 1'b0; hdr_err <= 1'b0; page_err <= 1'b0; not_found <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (req) begin
               id_q <= req_load;
               nl_q <= (int'(num_loads) > MAX_LOADS) ? NL_W'(MAX_LOADS) : num_loads;
               lidx <= '0; base <= '0;
               hdr_err <= 1'b0; page_err <= 1'b0; not_found <= 1'b0;
               st <= ST_SCAN;
            end
            ST_SCAN: begin
               if (lidx == nl_q) begin
                  not_found <= 1'b1; done <= 1'b1; st <= ST_IDLE;
               end else if (img_data == id_q) begin
                  cnt <= '0; st <= ST_HDR;
               end else begin
                  lidx <= lidx + 1'b1;
                  base <= base + IMG_AW'(LOAD_BYTES);
               end
            end
            ST_HDR: begin
               if (cnt == PB_W'(0)) hb0 <= img_data;
               if (cnt == PB_W'(1)) hb1 <= img_data;
               if (cnt == PB_W'(2)) hb2 <= img_data;
               if (cnt == PB_W'(COUNT_OFS))
                  npg <= (int'(img_data) > DATA_PAGES) ? PG_W'(DATA_PAGES) : PG_W'(img_data);
               if (cnt == PB_W'(HDR_SUM_BYTES - 1)) begin
                  if (sum_nxt != SUM_TARGET) hdr_err <= 1'b1;
                  pj <= '0; st <= ST_DESC;
               end
               cnt <= cnt + 1'b1;
            end
            ST_DESC: begin
               cnt <= '0;
               if (pj == npg) st <= ST_HOST;
               else begin
                  desc_q <= img_data[4:0];
                  st <= ST_CHK;
               end
            end
            ST_CHK: st <= ST_DATA;
            ST_DATA: begin
               cnt <= cnt + 1'b1;
               if (cnt == PB_W'(PAGE_BYTES - 1)) begin
                  if (sum_nxt != SUM_TARGET) page_err <= 1'b1;
                  pj <= pj + 1'b1;
                  st <= ST_DESC;
               end
            end
            ST_HOST: begin
               cnt <= cnt + 1'b1;
               if (cnt == PB_W'(2)) begin
                  done <= 1'b1; st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/multiload_engine_chk.sv
module multiload_engine_chk #(
   parameter int RAM_AW    = 13,
   parameter int RAM_WORDS = 6144
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic              host_we,
   input logic [7:0]        host_addr,
   input logic              not_found,
   input logic              hdr_err
);
   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   ram_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (int'(ram_addr) < RAM_WORDS));

   // R2
   ram_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (busy && !not_found));

   // R8
   host_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |-> (busy && (host_addr == 8'hFE || host_addr == 8'hFF || host_addr == 8'h80)));

   // R11
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !hdr_err && !not_found));
endmodule

bind multiload_engine multiload_engine_chk #(
   .RAM_AW(RAM_AW), .RAM_WORDS(RAM_BANKS * BANK_PAGES * PAGE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ram_we(ram_we),
   .ram_addr(ram_addr), .host_we(host_we), .host_addr(host_addr),
   .not_found(not_found), .hdr_err(hdr_err)
);

// File: tb/multiload_engine_tb.sv
module multiload_engine_tb;
   localparam int CLK_P   = 10;
   localparam int RAM_N   = 6144;
   localparam int LOAD_B  = 8448;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [7:0]  req_load = '0;
   logic [2:0]  num_loads = '0;
   logic [15:0] img_addr;
   logic [7:0]  img_data;
   logic        ram_we, host_we, busy, done, hdr_err, page_err, not_found;
   logic [12:0] ram_addr;
   logic [7:0]  ram_wdata, host_addr, host_wdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] ram_m [RAM_N];
   logic [7:0] ram_x [RAM_N];
   logic [7:0] host_m [256];
   logic [7:0] host_x [256];

   always #(CLK_P/2) clk = ~clk;

   multiload_engine u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_load(req_load), .num_loads(num_loads),
      .img_addr(img_addr), .img_data(img_data), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .busy(busy), .done(done), .hdr_err(hdr_err),
      .page_err(page_err), .not_found(not_found)
   );

   always_ff @(posedge clk) begin
      if (ram_we) ram_m[ram_addr] <= ram_wdata;
      if (host_we) host_m[host_addr] <= host_wdata;
   end

   function automatic logic [7:0] ld_id(int l);
      case (l) 0: return 8'h10; 1: return 8'h22; 2: return 8'h10; default: return 8'h33; endcase
   endfunction
   function automatic int ld_np(int l);
      case (l) 0: return 2; 1: return 3; default: return 1; endcase
   endfunction
   function automatic logic [7:0] ld_desc(int l, int j);
      case (l)
         0: return (j == 0) ? 8'h0C : 8'h01;
         1: return (j == 0) ? 8'h16 : (j == 1) ? 8'h07 : 8'h1C;
         2: return 8'h02;
         default: return 8'h1E;
      endcase
   endfunction
   function automatic logic [7:0] pg(int l, int p, int b);
      return 8'((l * 71) + (p * 29) + (b * 7) + (b >> 3));
   endfunction
   function automatic logic [7:0] hdr(int l, int h);
      logic [7:0] s;
      case (h)
         0: return 8'(l * 16 + 1);
         1: return 8'(l * 16 + 2);
         2: return 8'(l * 16 + 3);
         3: return 8'(ld_np(l));
         5: return ld_id(l);
         6: return 8'h5A;
         7: return 8'hA5;
         4: begin
            s = 8'h55;
            for (int i = 0; i < 8; i++) if (i != 4) s = s - hdr(l, i);
            return (l == 3) ? s + 8'd1 : s;
         end
         default: ;
      endcase
      if (h >= 16 && h < 16 + ld_np(l)) return ld_desc(l, h - 16);
      if (h >= 64 && h < 64 + ld_np(l)) begin
         s = 8'h55 - ld_desc(l, h - 64);
         for (int b = 0; b < 256; b++) s = s - pg(l, h - 64, b);
         return (l == 1 && h == 66) ? s + 8'd1 : s;
      end
      return 8'hFF;
   endfunction
   function automatic logic [7:0] img_byte(int a);
      int l, off;
      l = a / LOAD_B; off = a % LOAD_B;
      if (l >= 4) return 8'hEE;
      if (off < 8192) return pg(l, off >> 8, off & 255);
      return hdr(l, off - 8192);
   endfunction

   assign img_data = img_byte(int'(img_addr));

   task automatic chk(string r, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   task automatic apply_model(int l);
      for (int j = 0; j < ld_np(l); j++) begin
         logic [7:0] d;
         d = ld_desc(l, j);
         if (d[1:0] != 2'd3)
            for (int b = 0; b < 256; b++)
               ram_x[int'(d[1:0]) * 2048 + int'(d[4:2]) * 256 + b] = pg(l, j, b);
      end
      host_x[8'hFE] = hdr(l, 0);
      host_x[8'hFF] = hdr(l, 1);
      host_x[8'h80] = hdr(l, 2);
   endtask

   task automatic compare_mem(string r);
      int bad_r, bad_h;
      bad_r = 0; bad_h = 0;
      for (int i = 0; i < RAM_N; i++) if (ram_m[i] !== ram_x[i]) bad_r++;
      for (int i = 0; i < 256; i++) if (host_m[i] !== host_x[i]) bad_h++;
      chk(r, "RAM bytes differing", bad_r, 0);
      chk("R8", "console bytes differing", bad_h, 0);
   endtask

   // match < 0 means no record should match
   task automatic run(logic [7:0] id, int nl, int match, int exp_he, int exp_pe,
                      int exp_busy, bit poke);
      int bcnt, cyc;
      bcnt = 0; cyc = 0;
      @(negedge clk);
      req_load = id; num_loads = 3'(nl); req = 1'b1;
      while (1) begin
         @(negedge clk);
         req = 1'b0;
         cyc++;
         if (poke && cyc == 20) begin req = 1'b1; req_load = 8'h10; end
         if (busy) bcnt++;
         if (done || cyc > 5000) break;
      end
      chk("R10", "done seen", int'(done), 1);
      chk("R9", "busy cycles", bcnt, exp_busy);
      chk("R2", "not_found", int'(not_found), (match < 0) ? 1 : 0);
      chk("R3", "hdr_err", int'(hdr_err), exp_he);
      chk("R7", "page_err", int'(page_err), exp_pe);
      if (match >= 0) apply_model(match);
      compare_mem((match >= 0) ? "R5" : "R2");
      @(negedge clk);
      chk("R10", "done after one cycle", int'(done), 0);
   endtask

   initial begin
      for (int i = 0; i < RAM_N; i++) begin ram_m[i] = 8'h00; ram_x[i] = 8'h00; end
      for (int i = 0; i < 256; i++) begin host_m[i] = 8'h00; host_x[i] = 8'h00; end
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "busy after reset", int'(busy), 0);
      chk("R11", "done after reset", int'(done), 0);
      chk("R11", "ram_we after reset", int'(ram_we), 0);
      chk("R11", "host_we after reset", int'(host_we), 0);
      rst_n = 1'b1;
      // R1 R4 R5: record 0, two pages
      run(8'h10, 4, 0, 0, 0, 13 + 0 + 258 * 2, 1'b0);
      // R6 R7 R10: record 1, bank 3 page, bad page check, mid-run request ignored
      run(8'h22, 4, 1, 0, 1, 13 + 1 + 258 * 3, 1'b1);
      // R3: record 3 bad header still copied
      run(8'h33, 4, 3, 1, 0, 13 + 3 + 258 * 1, 1'b0);
      // R2 R1: record 3 outside num_loads
      run(8'h33, 3, -1, 0, 0, 4, 1'b0);
      // R2: num_loads zero
      run(8'h10, 0, -1, 0, 0, 1, 1'b0);
      // R1: duplicate id picks the first record; R10 flags cleared
      run(8'h10, 4, 0, 0, 0, 13 + 258 * 2, 1'b0);
      // R2: identifier that no record has
      run(8'h99, 4, -1, 0, 0, 5, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule